// File: doc/BRIEF.md
# Query-Based Victim Selector

This block picks the line to replace in one set of an inclusive last-level cache whose set is ordered by recency. When a lookup misses and the set is full, it does not simply take the least recently used line. It first asks the core caches whether they still hold that line. A line the cores still hold is treated as hot. It is moved to the most recently used position and the next oldest line is asked about instead. The first line the cores report absent is replaced, so inclusion never strips a line the cores are still using.

A configurable cap bounds how many questions one miss may ask. Once the cap is reached, the current oldest line is taken without asking. The cap has five settings, and one of them turns the questioning off so the set behaves as plain least-recently-used. When the fill data for the miss is ready before a choice is made, a mode input decides the response. Either the search keeps going until it ends by itself, or it stops and takes the current candidate. A candidate taken without the cores confirming it absent is flagged for back-invalidation. Each result also reports how many questions were asked, how many lines were rescued and whether the choice was forced.

Lookups that hit promote the line and answer at once. After the victim is chosen, the incoming tag is written into the chosen way as its newest line.

Top module: `query_victim_selector`

## Requirements
- R1: A request whose tag matches a valid way gives hitValid with that way on hitWay one cycle after acceptance, makes the way the newest line, and sends no query.
- R2: While any way is invalid, a miss takes the lowest-numbered invalid way with no query, vicWasValid=0, vicBackInv=0 and vicQueries=0.
- R3: On a miss in a full set, the first query carries the tag of the oldest line, and only one query is outstanding at any time.
- R4: A matching response with rspPresent=0 makes the queried line the victim with vicBackInv=0.
- R5: A matching response with rspPresent=1 promotes the queried line to newest and counts one rescue, and the new oldest line is queried next.
- R6: cfgLimit, captured when the miss is accepted, sets the most queries per miss: 0 gives 0, 1 gives 1, 2 gives 2, 3 gives 4, and 4 to 7 give 8. With a cap of 0 the oldest line is evicted at once, as in plain least-recently-used.
- R7: When the queries already sent equal the cap, the current oldest line is the victim with no further query, and vicBackInv=1.
- R8: With cfgForce=1, fillReady=1 during a search ends it: the current candidate is taken with vicForced=1 and vicBackInv=1, including when its query is still unanswered. With cfgForce=0, fillReady has no effect.
- R9: A response whose tag differs from the awaited one is ignored. After a forced pick leaves a query unanswered, no new query is sent until that response has arrived.
- R10: With each victim, vicQueries gives the queries sent and vicRescues the lines rescued during that miss.
- R11: vicValid is a one-cycle pulse. reqReady is low from the acceptance of a miss until its victim pulse, and the missing tag is written into the victim way as newest.
- R12: After reset all ways are invalid, reqReady=1 and hitValid, qryValid and vicValid are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgLimit | input | 3 | Query cap select (R6) |
| cfgForce | input | 1 | 1: fill readiness forces the choice; 0: search waits |
| reqValid | input | 1 | Lookup request |
| reqTag | input | TAG_W | Tag looked up |
| reqReady | output | 1 | Request accepted this cycle when high |
| hitValid | output | 1 | Lookup hit pulse |
| hitWay | output | WAY_W | Way that hit |
| fillReady | input | 1 | Fill data for the current miss is available |
| qryValid | output | 1 | Residency query pulse |
| qryTag | output | TAG_W | Tag being queried |
| rspValid | input | 1 | Residency response |
| rspTag | input | TAG_W | Tag the response refers to |
| rspPresent | input | 1 | 1: some core cache holds the line |
| vicValid | output | 1 | Victim result pulse |
| vicWay | output | WAY_W | Way chosen for replacement |
| vicTag | output | TAG_W | Tag previously held by that way (0 if it was invalid) |
| vicWasValid | output | 1 | The chosen way held a valid line |
| vicBackInv | output | 1 | The old line must be back-invalidated in the core caches |
| vicForced | output | 1 | The choice was forced by fill readiness |
| vicQueries | output | 4 | Queries sent during this miss |
| vicRescues | output | 4 | Lines promoted during this miss |

## Verification
The hardest situation to reach is a forced pick that leaves a query unanswered, followed straight away by a miss that must hold off its own query. The stimulus gets there by delaying the responder model's answer for several cycles and raising fill readiness right after the query leaves. It then sends the next miss at once, so that miss sits in its search while the old answer is still in flight. The cap settings are swept across every pattern of which ways the cores hold, with varied response delays, and a wrong-tag response claiming presence is sent ahead of the real one.

// File: rtl/qvs_pkg.sv
`timescale 1ns/1ps
package qvs_pkg;

  // Search controller states.
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SELECT = 2'd1,
    ST_WAIT   = 2'd2
  } selState_e;

  // Strobes from the controller to the set state.
  typedef struct packed {
    logic promote;
    logic install;
  } dpStrobe_t;

  localparam int CNT_W = 4;

  // Cap select to query count: 0,1,2,4 then 8 for all higher codes.
  function automatic logic [CNT_W-1:0] decodeLimit(input logic [2:0] sel);
    logic [CNT_W-1:0] lim;
    case (sel)
      3'd0:    lim = 4'd0;
      3'd1:    lim = 4'd1;
      3'd2:    lim = 4'd2;
      3'd3:    lim = 4'd4;
      default: lim = 4'd8;
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/qvs_set_state.sv
`timescale 1ns/1ps
module qvs_set_state
  import qvs_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [WAY_W-1:0] promoteWay,
  input  logic [WAY_W-1:0] installWay,
  input  logic [TAG_W-1:0] installTag,
  input  logic [TAG_W-1:0] lookupTag,
  output logic             lookupHit,
  output logic [WAY_W-1:0] lookupWay,
  output logic [WAY_W-1:0] lruWay,
  output logic [TAG_W-1:0] lruTag,
  output logic             anyInvalid,
  output logic [WAY_W-1:0] firstInvalid
);

  localparam int AGE_W = WAY_W;
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

  logic [TAG_W-1:0] tagArr [WAYS];
  logic [AGE_W-1:0] ageArr [WAYS];
  logic [WAYS-1:0]  validVec;
  logic [WAYS-1:0]  matchVec;
  logic [WAYS-1:0]  oldestVec;

  logic             touch;
  logic [WAY_W-1:0] touchWay;
  logic [AGE_W-1:0] touchAge;

  assign touch    = strobe.promote | strobe.install;
  assign touchWay = strobe.install ? installWay : promoteWay;
  assign touchAge = ageArr[touchWay];

  for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
    logic [TAG_W-1:0] tagR;
    logic [AGE_W-1:0] ageR;
    logic             validR;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tagR   <= '0;
        ageR   <= AGE_W'(gw);
        validR <= 1'b0;
      end else begin
        if (touch) begin
          if (touchWay == WAY_W'(gw)) begin
            ageR <= '0;
          end else if (ageR < touchAge) begin
            ageR <= ageR + 1'b1;
          end
        end
        if (strobe.install && (installWay == WAY_W'(gw))) begin
          tagR   <= installTag;
          validR <= 1'b1;
        end
      end
    end

    assign tagArr[gw]    = tagR;
    assign ageArr[gw]    = ageR;
    assign validVec[gw]  = validR;
    assign matchVec[gw]  = validR && (tagR == lookupTag);
    assign oldestVec[gw] = (ageR == OLDEST);
  end

  // Priority encoders; the lowest index wins.
  always_comb begin
    lookupWay    = '0;
    lruWay       = '0;
    firstInvalid = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (matchVec[i])  lookupWay    = WAY_W'(i);
      if (oldestVec[i]) lruWay       = WAY_W'(i);
      if (!validVec[i]) firstInvalid = WAY_W'(i);
    end
  end

  assign lookupHit  = |matchVec;
  assign anyInvalid = ~&validVec;
  assign lruTag     = tagArr[lruWay];

endmodule

// File: rtl/qvs_search_ctrl.sv
`timescale 1ns/1ps
module qvs_search_ctrl
  import qvs_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       cfgLimit,
  input  logic             cfgForce,
  input  logic             reqValid,
  input  logic [TAG_W-1:0] reqTag,
  output logic             reqReady,
  output logic             hitValid,
  output logic [WAY_W-1:0] hitWay,
  input  logic             fillReady,
  output logic             qryValid,
  output logic [TAG_W-1:0] qryTag,
  input  logic             rspValid,
  input  logic [TAG_W-1:0] rspTag,
  input  logic             rspPresent,
  output logic             vicValid,
  output logic [WAY_W-1:0] vicWay,
  output logic [TAG_W-1:0] vicTag,
  output logic             vicWasValid,
  output logic             vicBackInv,
  output logic             vicForced,
  output logic [CNT_W-1:0] vicQueries,
  output logic [CNT_W-1:0] vicRescues,
  // set state interface
  output logic [TAG_W-1:0] lookupTag,
  input  logic             lookupHit,
  input  logic [WAY_W-1:0] lookupWay,
  input  logic [WAY_W-1:0] lruWay,
  input  logic [TAG_W-1:0] lruTag,
  input  logic             anyInvalid,
  input  logic [WAY_W-1:0] firstInvalid,
  output dpStrobe_t        strobe,
  output logic [WAY_W-1:0] promoteWay,
  output logic [WAY_W-1:0] installWay,
  output logic [TAG_W-1:0] installTag
);

  selState_e        stateQ;
  logic [TAG_W-1:0] missTagQ;
  logic [WAY_W-1:0] pendWayQ;
  logic [TAG_W-1:0] pendTagQ;
  logic [CNT_W-1:0] qCntQ;
  logic [CNT_W-1:0] rCntQ;
  logic [CNT_W-1:0] limitQ;
  logic             staleQ;
  logic [TAG_W-1:0] staleTagQ;

  logic             forceNow;
  logic             rspMatch;
  logic             accept;
  logic             hitNow;
  logic             issue;
  logic             rescue;
  logic             decide;
  logic [WAY_W-1:0] decWay;
  logic [TAG_W-1:0] decTag;
  logic             decWasValid;
  logic             decBackInv;
  logic             decForced;

  assign reqReady   = (stateQ == ST_IDLE);
  assign lookupTag  = reqTag;
  assign installTag = missTagQ;
  assign forceNow   = cfgForce && fillReady;
  assign rspMatch   = rspValid && (rspTag == pendTagQ);

  always_comb begin
    strobe      = '0;
    promoteWay  = lruWay;
    installWay  = firstInvalid;
    accept      = 1'b0;
    hitNow      = 1'b0;
    issue       = 1'b0;
    rescue      = 1'b0;
    decide      = 1'b0;
    decWay      = lruWay;
    decTag      = lruTag;
    decWasValid = 1'b1;
    decBackInv  = 1'b1;
    decForced   = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          accept = 1'b1;
          if (lookupHit) begin
            hitNow         = 1'b1;
            strobe.promote = 1'b1;
            promoteWay     = lookupWay;
          end
        end
      end
      ST_SELECT: begin
        if (anyInvalid) begin
          decide      = 1'b1;
          decWay      = firstInvalid;
          decTag      = '0;
          decWasValid = 1'b0;
          decBackInv  = 1'b0;
        end else if (qCntQ == limitQ) begin
          decide = 1'b1;
        end else if (forceNow) begin
          decide    = 1'b1;
          decForced = 1'b1;
        end else if (!staleQ) begin
          issue = 1'b1;
        end
      end
      ST_WAIT: begin
        if (rspMatch) begin
          if (rspPresent) begin
            rescue         = 1'b1;
            strobe.promote = 1'b1;
            promoteWay     = pendWayQ;
          end else begin
            decide     = 1'b1;
            decWay     = pendWayQ;
            decTag     = pendTagQ;
            decBackInv = 1'b0;
          end
        end else if (forceNow) begin
          decide    = 1'b1;
          decWay    = pendWayQ;
          decTag    = pendTagQ;
          decForced = 1'b1;
        end
      end
      default: ;
    endcase
    if (decide) begin
      strobe.install = 1'b1;
      installWay     = decWay;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      missTagQ    <= '0;
      pendWayQ    <= '0;
      pendTagQ    <= '0;
      qCntQ       <= '0;
      rCntQ       <= '0;
      limitQ      <= '0;
      staleQ      <= 1'b0;
      staleTagQ   <= '0;
      hitValid    <= 1'b0;
      hitWay      <= '0;
      qryValid    <= 1'b0;
      qryTag      <= '0;
      vicValid    <= 1'b0;
      vicWay      <= '0;
      vicTag      <= '0;
      vicWasValid <= 1'b0;
      vicBackInv  <= 1'b0;
      vicForced   <= 1'b0;
      vicQueries  <= '0;
      vicRescues  <= '0;
    end else begin
      hitValid <= hitNow;
      if (hitNow) hitWay <= lookupWay;
      qryValid <= issue;
      if (issue) qryTag <= lruTag;
      vicValid <= decide;
      if (decide) begin
        vicWay      <= decWay;
        vicTag      <= decTag;
        vicWasValid <= decWasValid;
        vicBackInv  <= decBackInv;
        vicForced   <= decForced;
        vicQueries  <= qCntQ;
        vicRescues  <= rCntQ;
      end

      // An unanswered query left behind by a forced pick.
      if (stateQ == ST_WAIT && decide && decForced) begin
        staleQ    <= 1'b1;
        staleTagQ <= pendTagQ;
      end else if (staleQ && rspValid && (rspTag == staleTagQ)) begin
        staleQ <= 1'b0;
      end

      unique case (stateQ)
        ST_IDLE: begin
          if (accept && !lookupHit) begin
            stateQ   <= ST_SELECT;
            missTagQ <= reqTag;
            qCntQ    <= '0;
            rCntQ    <= '0;
            limitQ   <= decodeLimit(cfgLimit);
          end
        end
        ST_SELECT: begin
          if (decide) begin
            stateQ <= ST_IDLE;
          end else if (issue) begin
            stateQ   <= ST_WAIT;
            pendWayQ <= lruWay;
            pendTagQ <= lruTag;
            qCntQ    <= qCntQ + 1'b1;
          end
        end
        ST_WAIT: begin
          if (rescue) begin
            stateQ <= ST_SELECT;
            rCntQ  <= rCntQ + 1'b1;
          end else if (decide) begin
            stateQ <= ST_IDLE;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/query_victim_selector.sv
`timescale 1ns/1ps
module query_victim_selector
  import qvs_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       cfgLimit,
  input  logic             cfgForce,
  input  logic             reqValid,
  input  logic [TAG_W-1:0] reqTag,
  output logic             reqReady,
  output logic             hitValid,
  output logic [WAY_W-1:0] hitWay,
  input  logic             fillReady,
  output logic             qryValid,
  output logic [TAG_W-1:0] qryTag,
  input  logic             rspValid,
  input  logic [TAG_W-1:0] rspTag,
  input  logic             rspPresent,
  output logic             vicValid,
  output logic [WAY_W-1:0] vicWay,
  output logic [TAG_W-1:0] vicTag,
  output logic             vicWasValid,
  output logic             vicBackInv,
  output logic             vicForced,
  output logic [CNT_W-1:0] vicQueries,
  output logic [CNT_W-1:0] vicRescues
);

  dpStrobe_t        strobe;
  logic [WAY_W-1:0] promoteWay;
  logic [WAY_W-1:0] installWay;
  logic [TAG_W-1:0] installTag;
  logic [TAG_W-1:0] lookupTag;
  logic             lookupHit;
  logic [WAY_W-1:0] lookupWay;
  logic [WAY_W-1:0] lruWay;
  logic [TAG_W-1:0] lruTag;
  logic             anyInvalid;
  logic [WAY_W-1:0] firstInvalid;

  qvs_search_ctrl #(.WAYS(WAYS), .TAG_W(TAG_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgLimit     (cfgLimit),
    .cfgForce     (cfgForce),
    .reqValid     (reqValid),
    .reqTag       (reqTag),
    .reqReady     (reqReady),
    .hitValid     (hitValid),
    .hitWay       (hitWay),
    .fillReady    (fillReady),
    .qryValid     (qryValid),
    .qryTag       (qryTag),
    .rspValid     (rspValid),
    .rspTag       (rspTag),
    .rspPresent   (rspPresent),
    .vicValid     (vicValid),
    .vicWay       (vicWay),
    .vicTag       (vicTag),
    .vicWasValid  (vicWasValid),
    .vicBackInv   (vicBackInv),
    .vicForced    (vicForced),
    .vicQueries   (vicQueries),
    .vicRescues   (vicRescues),
    .lookupTag    (lookupTag),
    .lookupHit    (lookupHit),
    .lookupWay    (lookupWay),
    .lruWay       (lruWay),
    .lruTag       (lruTag),
    .anyInvalid   (anyInvalid),
    .firstInvalid (firstInvalid),
    .strobe       (strobe),
    .promoteWay   (promoteWay),
    .installWay   (installWay),
    .installTag   (installTag)
  );

  qvs_set_state #(.WAYS(WAYS), .TAG_W(TAG_W)) u_set (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .promoteWay   (promoteWay),
    .installWay   (installWay),
    .installTag   (installTag),
    .lookupTag    (lookupTag),
    .lookupHit    (lookupHit),
    .lookupWay    (lookupWay),
    .lruWay       (lruWay),
    .lruTag       (lruTag),
    .anyInvalid   (anyInvalid),
    .firstInvalid (firstInvalid)
  );

endmodule

// File: rtl/query_victim_selector_chk.sv
`timescale 1ns/1ps
module query_victim_selector_chk
  import qvs_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqReady,
  input logic             hitValid,
  input logic             qryValid,
  input logic [TAG_W-1:0] qryTag,
  input logic             rspValid,
  input logic [TAG_W-1:0] rspTag,
  input logic             vicValid,
  input logic             vicWasValid,
  input logic             vicBackInv,
  input logic             vicForced,
  input logic [CNT_W-1:0] vicQueries,
  input logic [CNT_W-1:0] vicRescues
);

  // Port-level record of the query in flight.
  logic             outQ;
  logic [TAG_W-1:0] outTagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ    <= 1'b0;
      outTagQ <= '0;
    end else if (qryValid) begin
      outQ    <= !(rspValid && (rspTag == qryTag));
      outTagQ <= qryTag;
    end else if (outQ && rspValid && (rspTag == outTagQ)) begin
      outQ <= 1'b0;
    end
  end

  // R3 R9
  single_query_chk: assert property (@(posedge clk) disable iff (!rstN)
    qryValid |-> !outQ);

  // R11
  busy_query_chk: assert property (@(posedge clk) disable iff (!rstN)
    qryValid |-> !reqReady);

  // R2
  invalid_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vicValid && !vicWasValid) |-> (vicQueries == '0 && !vicBackInv));

  // R8
  forced_backinv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vicValid && vicForced) |-> vicBackInv);

  // R4
  confirmed_absent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vicValid && vicWasValid && !vicBackInv) |-> (vicQueries != '0));

  // R10
  rescue_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    vicValid |-> (vicRescues <= vicQueries && vicQueries <= 4'd8));

  // R11
  vic_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    vicValid |=> !vicValid);

  // R1 R11
  one_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(vicValid && hitValid));

endmodule

bind query_victim_selector query_victim_selector_chk #(.TAG_W(TAG_W)) u_chk (.*);

// File: tb/query_victim_selector_tb.sv
`timescale 1ns/1ps
module query_victim_selector_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WAYS  = 4;
  localparam int TAG_W = 8;

  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] cfgLimit;
  logic       cfgForce;
  logic       reqValid;
  logic [7:0] reqTag;
  logic       reqReady;
  logic       hitValid;
  logic [1:0] hitWay;
  logic       fillReady;
  logic       qryValid;
  logic [7:0] qryTag;
  logic       rspValid;
  logic [7:0] rspTag;
  logic       rspPresent;
  logic       vicValid;
  logic [1:0] vicWay;
  logic [7:0] vicTag;
  logic       vicWasValid;
  logic       vicBackInv;
  logic       vicForced;
  logic [3:0] vicQueries;
  logic [3:0] vicRescues;

  always #(CLK_PERIOD / 2) clk = ~clk;

  query_victim_selector #(.WAYS(WAYS), .TAG_W(TAG_W)) u_dut (.*);

  int checks = 0;
  int fails  = 0;

  // Reference model of the set.
  logic [7:0] mTag   [4];
  bit         mValid [4];
  int         mAge   [4];

  // Responder controls.
  bit [3:0]   resMask = 4'h0;
  bit         allRes  = 1'b0;
  int         rspDelay = 0;
  bit         bogus   = 1'b0;
  int         overlapErr = 0;
  int         qSeen = 0;
  logic [7:0] heldTag;

  // Expected result of the current miss.
  int eW, eQ, eR;
  bit eWas, eBi, eForced;
  bit gotVic;
  bit rdyAfterAccept;
  logic [7:0] nextTag = 8'h20;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit isResident(input logic [7:0] t);
    if (allRes) return 1'b1;
    for (int w = 0; w < 4; w++)
      if (mValid[w] && mTag[w] == t) return resMask[w];
    return 1'b0;
  endfunction

  function automatic int mLru();
    int r = 0;
    for (int w = 0; w < 4; w++) if (mAge[w] == 3) r = w;
    return r;
  endfunction

  function automatic int mFirstInv();
    for (int w = 0; w < 4; w++) if (!mValid[w]) return w;
    return -1;
  endfunction

  task automatic mPromote(input int w);
    int a = mAge[w];
    for (int i = 0; i < 4; i++) begin
      if (i == w) mAge[i] = 0;
      else if (mAge[i] < a) mAge[i] = mAge[i] + 1;
    end
  endtask

  task automatic mInstall(input int w, input logic [7:0] t);
    mTag[w] = t;
    mValid[w] = 1'b1;
    mPromote(w);
  endtask

  function automatic int capOf(input int sel);
    if (sel == 0) return 0;
    if (sel == 1) return 1;
    if (sel == 2) return 2;
    if (sel == 3) return 4;
    return 8;
  endfunction

  // Expected outcome of a miss whose search is not forced.
  task automatic predict(input int lim);
    bit done = 1'b0;
    int fi = mFirstInv();
    eQ = 0; eR = 0; eForced = 1'b0;
    if (fi >= 0) begin
      eW = fi; eWas = 1'b0; eBi = 1'b0;
    end else begin
      eWas = 1'b1;
      while (!done) begin
        eW = mLru();
        if (eQ == lim) begin
          eBi = 1'b1; done = 1'b1;
        end else begin
          eQ++;
          if (isResident(mTag[eW])) begin
            mPromote(eW); eR++;
          end else begin
            eBi = 1'b0; done = 1'b1;
          end
        end
      end
    end
  endtask

  // Sends one missing tag; raises fillReady fillAt negedges after acceptance.
  task automatic runMiss(input logic [7:0] t, input int fillAt);
    int q0 = qSeen;
    @(negedge clk);
    reqValid = 1'b1; reqTag = t;
    @(negedge clk);
    reqValid = 1'b0;
    rdyAfterAccept = reqReady;
    gotVic = 1'b0;
    for (int c = 0; c < 400 && !gotVic; c++) begin
      if (fillAt >= 0 && c >= fillAt) fillReady = 1'b1;
      if (vicValid) gotVic = 1'b1;
      else @(negedge clk);
    end
    fillReady = 1'b0;
    if (!gotVic) begin
      checks++; fails++;
      $display("FAIL R11 no victim for tag %0h: actual none expected pulse", t);
    end else begin
      check("R2 R3 R4 R5 R6 R7 R8 R10", "way/was/bi/q/r/forced/seen",
            {19'd0, vicWay, vicWasValid, vicBackInv, vicQueries, vicRescues,
             vicForced, 4'(qSeen - q0)},
            {19'd0, 2'(eW), eWas, eBi, 4'(eQ), 4'(eR), eForced, 4'(eQ)});
      if (eWas) check("R3 R4 R7", "victim tag", {24'd0, vicTag}, {24'd0, mTag[eW]});
    end
    mInstall(eW, t);
  endtask

  task automatic runHit(input logic [7:0] t, input int w);
    @(negedge clk);
    reqValid = 1'b1; reqTag = t;
    @(negedge clk);
    reqValid = 1'b0;
    check("R1", "hit/way/qry", {29'd0, hitValid, hitWay, qryValid},
          {29'd0, 1'b1, 2'(w), 1'b0});
    mPromote(w);
  endtask

  // Core-cache responder model.
  initial begin
    rspValid = 1'b0; rspTag = '0; rspPresent = 1'b0;
    forever begin
      @(negedge clk);
      rspValid = 1'b0;
      if (qryValid) begin
        heldTag = qryTag;
        qSeen++;
        repeat (rspDelay) begin
          @(negedge clk);
          if (qryValid) overlapErr++;
        end
        if (bogus) begin
          rspValid = 1'b1; rspTag = heldTag ^ 8'hFF; rspPresent = 1'b1;
          @(negedge clk);
          if (qryValid) overlapErr++;
        end
        rspValid = 1'b1; rspTag = heldTag; rspPresent = isResident(heldTag);
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int w;
    rstN = 1'b0; cfgLimit = 3'd4; cfgForce = 1'b0;
    reqValid = 1'b0; reqTag = '0; fillReady = 1'b0;
    for (int i = 0; i < 4; i++) begin
      mTag[i] = '0; mValid[i] = 1'b0; mAge[i] = i;
    end
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", "ready/hit/qry/vic", {28'd0, reqReady, hitValid, qryValid, vicValid},
          {28'd0, 1'b1, 1'b0, 1'b0, 1'b0});
    rstN = 1'b1;

    // R2: filling an empty set uses invalid ways in index order.
    for (int i = 0; i < 4; i++) begin
      predict(8);
      runMiss(8'h10 + 8'(i), -1);
    end

    // R1: hit on the oldest line.
    runHit(8'h10, 0);

    // R3 R4 R5 R6 R7 R10: every cap select against every residency pattern.
    for (int sel = 0; sel < 6; sel++) begin
      for (int m = 0; m < 16; m++) begin
        cfgLimit = 3'(sel);
        resMask  = 4'(m);
        rspDelay = m % 3;
        predict(capOf(sel));
        runMiss(nextTag, -1);
        nextTag++;
      end
    end
    check("R9", "overlapping queries after sweep", overlapErr, 0);

    // R1 R11: a hit on the oldest line protects it from the next plain-LRU miss.
    w = mLru();
    runHit(mTag[w], w);
    cfgLimit = 3'd0;
    predict(0);
    check("R11", "hit line no longer oldest", {31'd0, (eW == w)}, 32'd0);
    runMiss(nextTag, -1); nextTag++;

    // R8 R9: forced pick while the query is still unanswered.
    cfgForce = 1'b1; cfgLimit = 3'd4; allRes = 1'b1; rspDelay = 6;
    eW = mLru(); eWas = 1'b1; eBi = 1'b1; eQ = 1; eR = 0; eForced = 1'b1;
    runMiss(nextTag, 1); nextTag++;
    check("R11", "reqReady low during search", {31'd0, rdyAfterAccept}, 32'd0);
    allRes = 1'b0; resMask = 4'h0; rspDelay = 0; cfgForce = 1'b0;
    // R9: the next miss must hold its query until the old answer arrives.
    predict(8);
    runMiss(nextTag, -1); nextTag++;
    check("R9", "no query while an answer is in flight", overlapErr, 0);

    // R8: fill ready before any query ends the search at once.
    cfgForce = 1'b1; resMask = 4'hF;
    eW = mLru(); eWas = 1'b1; eBi = 1'b1; eQ = 0; eR = 0; eForced = 1'b1;
    runMiss(nextTag, 0); nextTag++;

    // R8: with cfgForce=0 fill readiness is ignored.
    cfgForce = 1'b0; rspDelay = 1;
    resMask = 4'h0; resMask[mLru()] = 1'b1;
    predict(8);
    check("R8", "expected one rescue", eR, 1);
    runMiss(nextTag, 0); nextTag++;

    // R9: a wrong-tag response claiming presence is ignored.
    bogus = 1'b1; resMask = 4'h0; rspDelay = 1;
    predict(8);
    runMiss(nextTag, -1); nextTag++;
    bogus = 1'b0;
    check("R9", "overlapping queries at end", overlapErr, 0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule